// File: doc/BRIEF.md
# Serial Flash I/O Width Tracker

This block sits beside a serial NOR flash controller and keeps track of the data-line width the flash device is using: one line each way (single), two bidirectional lines (dual), or four bidirectional lines (quad). The shifter uses the three one-hot enables to decide which data pins it drives and which it samples. In single mode DQ0 carries data to the device and DQ1 carries data back. In dual mode DQ[1:0] are bidirectional. In quad mode DQ[3:0] are bidirectional.

The tracker watches the command byte of each transaction, the write-data and read-data byte strobes, and a one-cycle end-of-transaction pulse. It keeps shadow copies of the width bits from two device configuration registers. The persistent one is loaded by the device at power-up and on a reset command. The volatile one takes effect as soon as a write to it completes. Each shadow holds two active-low bits: a quad-disable bit and a dual-disable bit. The tracker follows which register the device is actually using and drives the enables from the active copy.

Top module: `qio_mode_tracker`

## Requirements
- R1: While reset is asserted, and after its release with no traffic, single_en is 1 and dual_en and quad_en are 0.
- R2: Exactly one of single_en, dual_en and quad_en is 1 on every cycle.
- R3: The width bits are active-low and quad wins: quad-disable 0 gives quad whatever the dual-disable bit is; quad-disable 1 with dual-disable 0 gives dual; both 1 give single.
- R4: A write byte under opcode 0xB1 (persistent register) loads its bits 3 (quad-disable) and 2 (dual-disable) into the persistent shadow and leaves the enables unchanged.
- R5: An end-of-transaction pulse under opcode 0x99 (device reset) makes the persistent shadow the active source, and the enables reflect it from the clock edge that samples the pulse.
- R6: A write byte under opcode 0x61 (volatile register) loads its bits 7 (quad-disable) and 6 (dual-disable) into the volatile shadow. The enables change only at the edge that samples the end-of-transaction pulse under 0x61, and then follow the volatile shadow.
- R7: A read byte under opcode 0x65 loads bits 7:6 into the volatile shadow. When the volatile register is the active source, the enables follow the read value at the same edge.
- R8: A read byte under opcode 0xB5 loads bits 3:2 into the persistent shadow. The enables follow it at the same edge only while the persistent register is active and has not been written since the last reset or reset command. After such a write, a read leaves the enables unchanged.
- R9: Only the first data byte of a transaction is captured. Later bytes are ignored, and the end-of-transaction pulse re-arms capture.
- R10: Byte strobes and end-of-transaction pulses under any other opcode, or in the wrong direction for the opcode, change neither shadow nor the enables.
- R11: Enables change only at a clock edge that samples a byte strobe or an end-of-transaction pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_byte | input | 8 | Opcode of the current transaction |
| wr_stb | input | 1 | Write data byte valid for one cycle |
| wr_byte | input | 8 | Write data byte |
| rd_stb | input | 1 | Read data byte valid for one cycle |
| rd_byte | input | 8 | Read data byte |
| xfer_done | input | 1 | One-cycle end-of-transaction pulse |
| single_en | output | 1 | Single-line mode enable |
| dual_en | output | 1 | Dual-line mode enable |
| quad_en | output | 1 | Quad-line mode enable |

## Verification
A corrupted shadow stays hidden until it becomes active: a bad persistent copy shows only at the next reset command, and a bad volatile copy only when its write completes. The bench therefore follows every shadow update with the command that activates it and checks the enables on the next falling edge. A wrong active-source state shows first as an enable change after a read that should have been ignored, or a missing change after one that should count, in the cycle right after the read strobe. The stale-persistent case and the second-byte case are each swept over all four bit patterns.

// File: rtl/qio_pkg.sv
package qio_pkg;

  // {quad_dis, dual_dis}, active-low enables
  typedef logic [1:0] mode_bits_t;

  typedef enum logic [1:0] {
    SRC_NV_LIVE  = 2'd0,
    SRC_NV_STALE = 2'd1,
    SRC_EV       = 2'd2
  } src_e;

  typedef struct packed {
    logic quad;
    logic dual;
    logic single;
  } width_oh_t;

  localparam mode_bits_t BITS_DEFAULT = 2'b11;

  function automatic width_oh_t bits_to_width(input mode_bits_t b);
    width_oh_t w;
    w = '0;
    if (!b[1])      w.quad   = 1'b1;
    else if (!b[0]) w.dual   = 1'b1;
    else            w.single = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/qio_rst_sync.sv
module qio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/qio_cmd_decode.sv
module qio_cmd_decode #(
  parameter int         DW        = 8,
  parameter logic [7:0] OP_NV_WR  = 8'hB1,
  parameter logic [7:0] OP_NV_RD  = 8'hB5,
  parameter logic [7:0] OP_EV_WR  = 8'h61,
  parameter logic [7:0] OP_EV_RD  = 8'h65,
  parameter logic [7:0] OP_RESET  = 8'h99
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] cmd_byte,
  input  logic          wr_stb,
  input  logic          rd_stb,
  input  logic          xfer_done,
  output logic          cap_nv_wr,
  output logic          cap_nv_rd,
  output logic          cap_ev_wr,
  output logic          cap_ev_rd,
  output logic          done_reset,
  output logic          done_ev_wr
);
  logic armed_q, armed_d;
  logic is_nv_wr, is_nv_rd, is_ev_wr, is_ev_rd, is_reset;

  assign is_nv_wr = (cmd_byte == DW'(OP_NV_WR));
  assign is_nv_rd = (cmd_byte == DW'(OP_NV_RD));
  assign is_ev_wr = (cmd_byte == DW'(OP_EV_WR));
  assign is_ev_rd = (cmd_byte == DW'(OP_EV_RD));
  assign is_reset = (cmd_byte == DW'(OP_RESET));

  // capture armed until the first byte of a transaction
  always_comb begin
    armed_d = armed_q;
    if (wr_stb || rd_stb) armed_d = 1'b0;
    if (xfer_done)        armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b1;
    else        armed_q <= armed_d;
  end

  always_comb begin
    cap_nv_wr  = armed_q && wr_stb && is_nv_wr;
    cap_nv_rd  = armed_q && rd_stb && is_nv_rd;
    cap_ev_wr  = armed_q && wr_stb && is_ev_wr;
    cap_ev_rd  = armed_q && rd_stb && is_ev_rd;
    done_reset = xfer_done && is_reset;
    done_ev_wr = xfer_done && is_ev_wr;
  end
endmodule

// File: rtl/qio_cfg_shadow.sv
module qio_cfg_shadow
  import qio_pkg::*;
#(
  parameter int DW       = 8,
  parameter int DUAL_POS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cap,
  input  logic [DW-1:0] wr_byte,
  input  logic          rd_cap,
  input  logic [DW-1:0] rd_byte,
  output mode_bits_t    bits_d,
  output mode_bits_t    bits_q
);
  always_comb begin
    bits_d = bits_q;
    if (wr_cap)      bits_d = wr_byte[DUAL_POS +: 2];
    else if (rd_cap) bits_d = rd_byte[DUAL_POS +: 2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                bits_q <= BITS_DEFAULT;
    else if (wr_cap || rd_cap) bits_q <= bits_d;
  end
endmodule

// File: rtl/qio_mode_select.sv
module qio_mode_select
  import qio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_nv_wr,
  input  logic       cap_nv_rd,
  input  logic       cap_ev_rd,
  input  logic       done_reset,
  input  logic       done_ev_wr,
  input  mode_bits_t nv_d,
  input  mode_bits_t ev_d,
  output mode_bits_t act_d,
  output src_e       src_q
);
  src_e       src_d;
  mode_bits_t act_q;
  logic       act_en;

  always_comb begin
    src_d = src_q;
    act_d = act_q;
    if (done_reset) begin
      src_d = SRC_NV_LIVE;
      act_d = nv_d;
    end else if (done_ev_wr) begin
      src_d = SRC_EV;
      act_d = ev_d;
    end else begin
      if (cap_nv_rd && src_q == SRC_NV_LIVE) act_d = nv_d;
      if (cap_ev_rd && src_q == SRC_EV)      act_d = ev_d;
      if (cap_nv_wr && src_q == SRC_NV_LIVE) src_d = SRC_NV_STALE;
    end
  end

  assign act_en = done_reset || done_ev_wr || cap_nv_rd || cap_ev_rd || cap_nv_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_NV_LIVE;
      act_q <= BITS_DEFAULT;
    end else if (act_en) begin
      src_q <= src_d;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/qio_mode_out.sv
module qio_mode_out
  import qio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  mode_bits_t act_d,
  output logic       single_en,
  output logic       dual_en,
  output logic       quad_en
);
  width_oh_t oh_d, oh_q;

  assign oh_d = bits_to_width(act_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oh_q <= '{quad: 1'b0, dual: 1'b0, single: 1'b1};
    else        oh_q <= oh_d;
  end

  assign single_en = oh_q.single;
  assign dual_en   = oh_q.dual;
  assign quad_en   = oh_q.quad;
endmodule

// File: rtl/qio_mode_tracker.sv
module qio_mode_tracker
  import qio_pkg::*;
#(
  parameter int         DW          = 8,
  parameter int         SYNC_STAGES = 2,
  parameter int         NV_DUAL_POS = 2,
  parameter int         EV_DUAL_POS = 6,
  parameter logic [7:0] OP_NV_WR    = 8'hB1,
  parameter logic [7:0] OP_NV_RD    = 8'hB5,
  parameter logic [7:0] OP_EV_WR    = 8'h61,
  parameter logic [7:0] OP_EV_RD    = 8'h65,
  parameter logic [7:0] OP_RESET    = 8'h99
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] cmd_byte,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_byte,
  input  logic          rd_stb,
  input  logic [DW-1:0] rd_byte,
  input  logic          xfer_done,
  output logic          single_en,
  output logic          dual_en,
  output logic          quad_en
);
  localparam int NREG = 2; // 0: persistent, 1: volatile

  logic       srst_n;
  logic       cap_nv_wr, cap_nv_rd, cap_ev_wr, cap_ev_rd;
  logic       done_reset, done_ev_wr;
  logic       wr_cap [NREG];
  logic       rd_cap [NREG];
  mode_bits_t shd_d  [NREG];
  mode_bits_t shd_q  [NREG];
  mode_bits_t nv_bits, ev_bits, act_d;
  src_e       src_q;

  qio_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  qio_cmd_decode #(
    .DW(DW), .OP_NV_WR(OP_NV_WR), .OP_NV_RD(OP_NV_RD),
    .OP_EV_WR(OP_EV_WR), .OP_EV_RD(OP_EV_RD), .OP_RESET(OP_RESET)
  ) u_dec (
    .clk(clk), .rst_n(srst_n), .cmd_byte(cmd_byte),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .xfer_done(xfer_done),
    .cap_nv_wr(cap_nv_wr), .cap_nv_rd(cap_nv_rd),
    .cap_ev_wr(cap_ev_wr), .cap_ev_rd(cap_ev_rd),
    .done_reset(done_reset), .done_ev_wr(done_ev_wr)
  );

  assign wr_cap[0] = cap_nv_wr;
  assign rd_cap[0] = cap_nv_rd;
  assign wr_cap[1] = cap_ev_wr;
  assign rd_cap[1] = cap_ev_rd;

  for (genvar g = 0; g < NREG; g++) begin : g_shadow
    localparam int POS = (g == 0) ? NV_DUAL_POS : EV_DUAL_POS;
    qio_cfg_shadow #(.DW(DW), .DUAL_POS(POS)) u_shd (
      .clk(clk), .rst_n(srst_n),
      .wr_cap(wr_cap[g]), .wr_byte(wr_byte),
      .rd_cap(rd_cap[g]), .rd_byte(rd_byte),
      .bits_d(shd_d[g]), .bits_q(shd_q[g])
    );
  end

  assign nv_bits = shd_q[0];
  assign ev_bits = shd_q[1];

  qio_mode_select u_sel (
    .clk(clk), .rst_n(srst_n),
    .cap_nv_wr(cap_nv_wr), .cap_nv_rd(cap_nv_rd), .cap_ev_rd(cap_ev_rd),
    .done_reset(done_reset), .done_ev_wr(done_ev_wr),
    .nv_d(shd_d[0]), .ev_d(shd_d[1]),
    .act_d(act_d), .src_q(src_q)
  );

  qio_mode_out u_out (
    .clk(clk), .rst_n(srst_n), .act_d(act_d),
    .single_en(single_en), .dual_en(dual_en), .quad_en(quad_en)
  );
endmodule

module qio_mode_tracker_chk #(
  parameter logic [7:0] OP_NV_WR = 8'hB1,
  parameter logic [7:0] OP_EV_WR = 8'h61,
  parameter logic [7:0] OP_RESET = 8'h99
) (
  input logic       clk,
  input logic       rst_n,
  input logic       srst_n,
  input logic [7:0] cmd_byte,
  input logic       wr_stb,
  input logic       rd_stb,
  input logic       xfer_done,
  input logic [1:0] nv_bits,
  input logic [1:0] ev_bits,
  input logic       single_en,
  input logic       dual_en,
  input logic       quad_en
);
  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_single_chk: assert (single_en && !dual_en && !quad_en);
    end
  end

  // R2
  one_hot_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $countones({single_en, dual_en, quad_en}) == 1);

  // R4
  nv_write_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_stb && !xfer_done && cmd_byte == OP_NV_WR) |=>
      $stable({single_en, dual_en, quad_en}));

  // R5
  reset_cmd_follow_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (xfer_done && cmd_byte == OP_RESET) |=>
      (quad_en == !nv_bits[1]) && (dual_en == (nv_bits[1] && !nv_bits[0])));

  // R6
  ev_done_follow_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (xfer_done && cmd_byte == OP_EV_WR) |=>
      (quad_en == !ev_bits[1]) && (dual_en == (ev_bits[1] && !ev_bits[0])));

  // R11
  no_event_stable_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!wr_stb && !rd_stb && !xfer_done) |=>
      $stable({single_en, dual_en, quad_en}));
endmodule

bind qio_mode_tracker qio_mode_tracker_chk #(
  .OP_NV_WR(OP_NV_WR), .OP_EV_WR(OP_EV_WR), .OP_RESET(OP_RESET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .srst_n(srst_n), .cmd_byte(cmd_byte),
  .wr_stb(wr_stb), .rd_stb(rd_stb), .xfer_done(xfer_done),
  .nv_bits(nv_bits), .ev_bits(ev_bits),
  .single_en(single_en), .dual_en(dual_en), .quad_en(quad_en)
);

// File: tb/sim_qio_mode_tracker.sv
module sim_qio_mode_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] cmd_byte, wr_byte, rd_byte;
  logic       wr_stb, rd_stb, xfer_done;
  logic       single_en, dual_en, quad_en;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  // reference state, built from the requirements
  logic [1:0] m_nv, m_ev, m_act;
  int         m_src;   // 0 persistent live, 1 persistent stale, 2 volatile
  bit         m_armed;

  always #(CLK_PERIOD/2) clk = ~clk;

  qio_mode_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cmd_byte(cmd_byte),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .rd_stb(rd_stb), .rd_byte(rd_byte),
    .xfer_done(xfer_done),
    .single_en(single_en), .dual_en(dual_en), .quad_en(quad_en)
  );

  function automatic logic [2:0] width_of(input logic [1:0] b);
    // {quad, dual, single}
    if (!b[1])      return 3'b100;
    else if (!b[0]) return 3'b010;
    else            return 3'b001;
  endfunction

  task automatic check(input string req, input logic [2:0] exp);
    logic [2:0] got;
    got = {quad_en, dual_en, single_en};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: {quad,dual,single} got %b expected %b", req, got, exp);
    end
  endtask

  // one data byte; dir 0 write, 1 read
  task automatic send_byte(input logic [7:0] op, input bit dir,
                           input logic [7:0] b, input string req);
    cmd_byte = op;
    if (dir) begin rd_stb = 1'b1; rd_byte = b; end
    else     begin wr_stb = 1'b1; wr_byte = b; end
    @(posedge clk);
    if (m_armed) begin
      if (!dir && op == 8'hB1) begin
        m_nv = b[3:2];
        if (m_src == 0) m_src = 1;
      end
      if (dir && op == 8'hB5) begin
        m_nv = b[3:2];
        if (m_src == 0) m_act = m_nv;
      end
      if (!dir && op == 8'h61) m_ev = b[7:6];
      if (dir && op == 8'h65) begin
        m_ev = b[7:6];
        if (m_src == 2) m_act = m_ev;
      end
    end
    m_armed = 0;
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
    check(req, width_of(m_act));
  endtask

  task automatic finish_xact(input logic [7:0] op, input string req);
    cmd_byte  = op;
    xfer_done = 1'b1;
    @(posedge clk);
    m_armed = 1;
    if (op == 8'h99) begin m_act = m_nv; m_src = 0; end
    if (op == 8'h61) begin m_act = m_ev; m_src = 2; end
    @(negedge clk);
    xfer_done = 1'b0;
    check(req, width_of(m_act));
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) @(negedge clk);
    check(req, width_of(m_act));
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!ended) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; cmd_byte = 8'h00; wr_byte = 8'h00; rd_byte = 8'h00;
    wr_stb = 1'b0; rd_stb = 1'b0; xfer_done = 1'b0;
    m_nv = 2'b11; m_ev = 2'b11; m_act = 2'b11; m_src = 0; m_armed = 1;

    // R1: reset state, during and after reset
    repeat (3) @(negedge clk);
    check("R1", 3'b001);
    rst_n = 1'b1;
    idle(4, "R1");

    // R3 R4 R5: persistent shadow written, activated by reset command
    for (int p = 0; p < 4; p++) begin
      send_byte(8'hB1, 0, {4'(p * 5 + 3), 2'(p), 2'(3 - p)}, "R4");
      finish_xact(8'hB1, "R4");
      finish_xact(8'h99, "R5");
      check("R3", width_of(2'(p)));
    end

    // R6: volatile write takes effect only at end of transaction
    for (int p = 0; p < 4; p++) begin
      finish_xact(8'h99, "R6");
      send_byte(8'h61, 0, {2'(3 - p), 6'(p * 11)}, "R6");
      finish_xact(8'h61, "R6");
      check("R6", width_of(2'(3 - p)));
    end

    // R7: volatile read while volatile active updates at once
    for (int p = 0; p < 4; p++) begin
      send_byte(8'h65, 1, {2'(p), 6'(p * 7 + 1)}, "R7");
      check("R7", width_of(2'(p)));
      finish_xact(8'h65, "R7");
    end

    // R8: persistent read while live, then stale after a write
    for (int p = 0; p < 4; p++) begin
      finish_xact(8'h99, "R8");
      send_byte(8'hB5, 1, {4'(p), 2'(p), 2'(p)}, "R8");
      check("R8", width_of(2'(p)));
      finish_xact(8'hB5, "R8");
      send_byte(8'hB1, 0, {4'h0, 2'(3 - p), 2'b00}, "R8");
      finish_xact(8'hB1, "R8");
      send_byte(8'hB5, 1, {4'hF, 2'(p ^ 1), 2'b11}, "R8");
      check("R8", width_of(2'(p)));
      finish_xact(8'hB5, "R8");
      finish_xact(8'h99, "R8");
      check("R8", width_of(2'(p ^ 1)));
    end

    // R9: only the first byte counts; end of transaction re-arms
    for (int p = 0; p < 4; p++) begin
      send_byte(8'hB1, 0, {4'h0, 2'(p), 2'b00}, "R9");
      send_byte(8'hB1, 0, {4'h0, 2'(~p), 2'b00}, "R9");
      finish_xact(8'hB1, "R9");
      finish_xact(8'h99, "R9");
      check("R9", width_of(2'(p)));
      send_byte(8'h61, 0, {2'(p ^ 2), 6'h00}, "R9");
      send_byte(8'h61, 0, {2'(p ^ 1), 6'h00}, "R9");
      finish_xact(8'h61, "R9");
      check("R9", width_of(2'(p ^ 2)));
    end

    // R10: foreign opcodes and wrong directions change nothing
    finish_xact(8'h99, "R10");
    for (int k = 0; k < 4; k++) begin
      logic [7:0] op;
      op = (k == 0) ? 8'h05 : (k == 1) ? 8'h9F : (k == 2) ? 8'h03 : 8'h98;
      send_byte(op, k[0], 8'h00, "R10");
      finish_xact(op, "R10");
      send_byte(8'h61, 1, 8'h00, "R10");
      finish_xact(8'h65, "R10");
      send_byte(8'hB5, 0, 8'h00, "R10");
      finish_xact(8'hB5, "R10");
      idle(2, "R11");
    end
    // shadows untouched: activate each and compare with model
    finish_xact(8'h99, "R10");
    finish_xact(8'h61, "R10");

    ended = 1;
    summary();
  end
endmodule